// File: doc/BRIEF.md
# Pulse and Quadrature Event Counter

This block counts events derived from two sampled digital inputs, `s0` and `s1`. In the single-input modes it counts one chosen edge of `s0`. The count direction comes from a configuration bit, and `s1` can optionally reverse it. In the quadrature modes it treats `s0`/`s1` as a two-phase encoder pair. It takes the direction from their phase relation and resolves one, two or four counts per encoder period.

Two counters share one decoded event stream. The main counter and the auxiliary counter each pick which event kinds they follow. Both wrap at a common TOP limit, and both can reload to half of TOP on a wrap instead of to 0 or TOP. A staged TOP value moves into the active limit when the main counter wraps. Four sticky wrap flags, with separate set, clear and enable inputs, drive a single interrupt line.

All configuration arrives on ports and is expected to be quasi-static. The inputs are assumed to be already synchronous to `clk`.

Top module: `quad_pulse_counter`

## Requirements
- R1: After reset, `count` and `auxCount` are 0, `top` and `topBuf` are all ones, `flags` is 0 and `irq` is low.
- R2: Mode codes are: 0 off, 1 sampled single-input, 2 edge single-input, 3 edge quadrature, 4 quadrature 1X, 5 quadrature 2X, 6 quadrature 4X. In code 0 and in the unused code 7 no counter changes.
- R3: In modes 1 and 2, `negEdge` low counts rising edges of `s0` and `negEdge` high counts falling edges of `s0`.
- R4: In modes 1 and 2, `countDown` high makes each event a down event. With `s1DirEn` high, `s1` low reverses that direction and `s1` high keeps it.
- R5: In quadrature, a phase where `s0` leads `s1` counts up. Modes 3 and 4 count only on rising `s0` (up when `s1` is low). Mode 5 counts on both `s0` edges. Mode 6 counts on every edge of either input, and simultaneous edges on both are ignored. `negEdge` high inverts the decoded direction.
- R6: Without hysteresis, an up event at TOP wraps to 0, and a down event at 0 wraps to TOP. Flag bits are: [0] main overflow, [1] main underflow, [2] auxiliary overflow, [3] auxiliary underflow.
- R7: With `hystEn` high, every overflow or underflow of either counter reloads it with TOP shifted right by one.
- R8: Each event select uses these codes: 0 follow up and down events, 1 up events only, 2 down events only, 3 no events. `mainEvSel` governs `count` and `auxEvSel` governs `auxCount`.
- R9: `topBufWr` writes only `topBuf`. The active `top` takes the old `topBuf` value on a main-counter wrap. `loadEn` writes `count` and both TOP registers directly and clears `auxCount`.
- R10: A `flagSet` bit or a hardware wrap sets a flag, and a `flagClr` bit clears it; set wins when both occur in the same cycle. `irq` is high when any flag is set whose `intEnable` bit is set.
- R11: A level change on `s0` reaches `count` on the second rising clock edge after it is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rstN | input | 1 | Active-low synchronous reset |
| s0 | input | 1 | Count input / phase A |
| s1 | input | 1 | Direction input / phase B |
| mode | input | 3 | Operating mode code |
| negEdge | input | 1 | Edge polarity / quadrature direction invert |
| countDown | input | 1 | Single-input direction (1 = down) |
| s1DirEn | input | 1 | Let `s1` reverse the single-input direction |
| hystEn | input | 1 | Reload to TOP/2 on wrap |
| mainEvSel | input | 2 | Main counter event select |
| auxEvSel | input | 2 | Auxiliary counter event select |
| loadEn | input | 1 | Load count and TOP |
| loadCnt | input | W | Main counter load value |
| loadTop | input | W | TOP load value (active and staged) |
| topBufWr | input | 1 | Write staged TOP |
| topBufData | input | W | Staged TOP write data |
| flagSet | input | 4 | Flag set strobes |
| flagClr | input | 4 | Flag clear strobes |
| intEnable | input | 4 | Interrupt enable mask |
| count | output | W | Main counter |
| auxCount | output | W | Auxiliary counter |
| top | output | W | Active TOP |
| topBuf | output | W | Staged TOP |
| flags | output | 4 | Sticky wrap flags |
| irq | output | 1 | Masked interrupt |

## Verification
A corrupted edge history shows at `count` as a spurious or missing step two clock edges after the input moves. The same delay applies to a wrong direction term. Wrong wrap logic shows in the very next cycle: `count` lands on a value other than 0, TOP or TOP/2, and the matching flag bit either stays clear or sets without a boundary crossing. A mis-staged TOP stays hidden until the next main wrap. It then shows as a changed cycle length, so the checks pair each buffer write with a full wrap sequence.

// File: rtl/qpc_pkg.sv
`timescale 1ns/1ps
package qpc_pkg;

  typedef enum logic [2:0] {
    MODE_OFF         = 3'd0,
    MODE_SMP_SINGLE  = 3'd1,
    MODE_EDGE_SINGLE = 3'd2,
    MODE_EDGE_QUAD   = 3'd3,
    MODE_QUAD_1X     = 3'd4,
    MODE_QUAD_2X     = 3'd5,
    MODE_QUAD_4X     = 3'd6,
    MODE_RSVD        = 3'd7
  } qpcMode_e;

  typedef enum logic [1:0] {
    EV_BOTH = 2'd0,
    EV_UP   = 2'd1,
    EV_DOWN = 2'd2,
    EV_NONE = 2'd3
  } evSel_e;

  // strobes handed from control to datapath
  typedef struct packed {
    logic mainUp;
    logic mainDown;
    logic auxUp;
    logic auxDown;
  } cntStrobe_t;

  localparam int NUM_LANES = 2;
  localparam int NUM_FLAGS = 2 * NUM_LANES;

  // returns {up, down} after applying an event select
  function automatic logic [1:0] evFilter(evSel_e sel, logic up, logic down);
    logic [1:0] res;
    unique case (sel)
      EV_BOTH: res = {up, down};
      EV_UP:   res = {up, 1'b0};
      EV_DOWN: res = {1'b0, down};
      default: res = 2'b00;
    endcase
    return res;
  endfunction

endpackage

// File: rtl/qpc_ctrl.sv
`timescale 1ns/1ps
module qpc_ctrl
  import qpc_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       s0,
  input  logic       s1,
  input  logic [2:0] mode,
  input  logic       negEdge,
  input  logic       countDown,
  input  logic       s1DirEn,
  input  logic [1:0] mainEvSel,
  input  logic [1:0] auxEvSel,
  output cntStrobe_t strobe
);

  logic s0Now, s1Now, s0Prev, s1Prev;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      s0Now  <= 1'b0;
      s1Now  <= 1'b0;
      s0Prev <= 1'b0;
      s1Prev <= 1'b0;
    end else begin
      s0Now  <= s0;
      s1Now  <= s1;
      s0Prev <= s0Now;
      s1Prev <= s1Now;
    end
  end

  logic s0Rise, s0Fall, s1Rise, s1Fall, s0Edge, s1Edge;
  logic singleEdge, singleDown, phaseAUp, phaseBUp;
  logic evt, evtUp, upEv, downEv;
  qpcMode_e modeSel;

  assign modeSel = qpcMode_e'(mode);
  assign s0Rise  = s0Now & ~s0Prev;
  assign s0Fall  = ~s0Now & s0Prev;
  assign s1Rise  = s1Now & ~s1Prev;
  assign s1Fall  = ~s1Now & s1Prev;
  assign s0Edge  = s0Rise | s0Fall;
  assign s1Edge  = s1Rise | s1Fall;

  assign singleEdge = negEdge ? s0Fall : s0Rise;
  assign singleDown = countDown ^ (s1DirEn & ~s1Now);

  // phase A moving: up when A leads B
  assign phaseAUp = s0Rise ? ~s1Now : s1Now;
  // phase B moving: up when B trails A
  assign phaseBUp = s1Rise ? s0Now : ~s0Now;

  always_comb begin
    evt   = 1'b0;
    evtUp = 1'b0;
    unique case (modeSel)
      MODE_SMP_SINGLE, MODE_EDGE_SINGLE: begin
        evt   = singleEdge;
        evtUp = ~singleDown;
      end
      MODE_EDGE_QUAD, MODE_QUAD_1X: begin
        evt   = s0Rise;
        evtUp = ~s1Now ^ negEdge;
      end
      MODE_QUAD_2X: begin
        evt   = s0Edge;
        evtUp = phaseAUp ^ negEdge;
      end
      MODE_QUAD_4X: begin
        evt   = s0Edge ^ s1Edge;
        evtUp = (s0Edge ? phaseAUp : phaseBUp) ^ negEdge;
      end
      default: begin
        evt   = 1'b0;
        evtUp = 1'b0;
      end
    endcase
  end

  assign upEv   = evt & evtUp;
  assign downEv = evt & ~evtUp;

  always_comb begin
    {strobe.mainUp, strobe.mainDown} = evFilter(evSel_e'(mainEvSel), upEv, downEv);
    {strobe.auxUp,  strobe.auxDown}  = evFilter(evSel_e'(auxEvSel),  upEv, downEv);
  end

endmodule

// File: rtl/qpc_lane.sv
`timescale 1ns/1ps
module qpc_lane #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         load,
  input  logic [W-1:0] loadVal,
  input  logic         up,
  input  logic         down,
  input  logic         hystEn,
  input  logic [W-1:0] top,
  output logic [W-1:0] cnt,
  output logic         ofl,
  output logic         ufl
);

  localparam logic [W-1:0] ONE = W'(1);

  logic [W-1:0] nxt, half;

  assign half = top >> 1;

  always_comb begin
    nxt = cnt;
    ofl = 1'b0;
    ufl = 1'b0;
    if (up) begin
      if (cnt == top) begin
        ofl = 1'b1;
        nxt = hystEn ? half : '0;
      end else begin
        nxt = cnt + ONE;
      end
    end else if (down) begin
      if (cnt == '0) begin
        ufl = 1'b1;
        nxt = hystEn ? half : top;
      end else begin
        nxt = cnt - ONE;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)     cnt <= '0;
    else if (load) cnt <= loadVal;
    else           cnt <= nxt;
  end

endmodule

// File: rtl/qpc_datapath.sv
`timescale 1ns/1ps
module qpc_datapath
  import qpc_pkg::*;
#(
  parameter int W = 16
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  cntStrobe_t           strobe,
  input  logic                 hystEn,
  input  logic                 loadEn,
  input  logic [W-1:0]         loadCnt,
  input  logic [W-1:0]         loadTop,
  input  logic                 topBufWr,
  input  logic [W-1:0]         topBufData,
  input  logic [NUM_FLAGS-1:0] flagSet,
  input  logic [NUM_FLAGS-1:0] flagClr,
  input  logic [NUM_FLAGS-1:0] intEnable,
  output logic [W-1:0]         count,
  output logic [W-1:0]         auxCount,
  output logic [W-1:0]         top,
  output logic [W-1:0]         topBuf,
  output logic [NUM_FLAGS-1:0] flags,
  output logic                 irq
);

  logic [W-1:0] laneCnt [NUM_LANES];
  logic [W-1:0] laneLoad[NUM_LANES];
  logic         laneUp  [NUM_LANES];
  logic         laneDn  [NUM_LANES];
  logic         laneOfl [NUM_LANES];
  logic         laneUfl [NUM_LANES];
  logic [NUM_FLAGS-1:0] hwFlags;

  assign laneLoad[0] = loadCnt;
  assign laneLoad[1] = '0;
  assign laneUp[0]   = strobe.mainUp;
  assign laneDn[0]   = strobe.mainDown;
  assign laneUp[1]   = strobe.auxUp;
  assign laneDn[1]   = strobe.auxDown;

  for (genvar g = 0; g < NUM_LANES; g++) begin : gLane
    qpc_lane #(.W(W)) u_lane (
      .clk    (clk),
      .rstN   (rstN),
      .load   (loadEn),
      .loadVal(laneLoad[g]),
      .up     (laneUp[g]),
      .down   (laneDn[g]),
      .hystEn (hystEn),
      .top    (top),
      .cnt    (laneCnt[g]),
      .ofl    (laneOfl[g]),
      .ufl    (laneUfl[g])
    );
    assign hwFlags[2*g]   = laneOfl[g] & ~loadEn;
    assign hwFlags[2*g+1] = laneUfl[g] & ~loadEn;
  end

  assign count    = laneCnt[0];
  assign auxCount = laneCnt[1];

  logic mainWrap;
  assign mainWrap = hwFlags[0] | hwFlags[1];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      top    <= '1;
      topBuf <= '1;
    end else if (loadEn) begin
      top    <= loadTop;
      topBuf <= loadTop;
    end else begin
      if (topBufWr) topBuf <= topBufData;
      if (mainWrap) top    <= topBuf;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) flags <= '0;
    else       flags <= (flags & ~flagClr) | flagSet | hwFlags;
  end

  assign irq = |(flags & intEnable);

endmodule

// File: rtl/quad_pulse_counter.sv
`timescale 1ns/1ps
module quad_pulse_counter
  import qpc_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         s0,
  input  logic         s1,
  input  logic [2:0]   mode,
  input  logic         negEdge,
  input  logic         countDown,
  input  logic         s1DirEn,
  input  logic         hystEn,
  input  logic [1:0]   mainEvSel,
  input  logic [1:0]   auxEvSel,
  input  logic         loadEn,
  input  logic [W-1:0] loadCnt,
  input  logic [W-1:0] loadTop,
  input  logic         topBufWr,
  input  logic [W-1:0] topBufData,
  input  logic [3:0]   flagSet,
  input  logic [3:0]   flagClr,
  input  logic [3:0]   intEnable,
  output logic [W-1:0] count,
  output logic [W-1:0] auxCount,
  output logic [W-1:0] top,
  output logic [W-1:0] topBuf,
  output logic [3:0]   flags,
  output logic         irq
);

  cntStrobe_t strobe;

  qpc_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .s0       (s0),
    .s1       (s1),
    .mode     (mode),
    .negEdge  (negEdge),
    .countDown(countDown),
    .s1DirEn  (s1DirEn),
    .mainEvSel(mainEvSel),
    .auxEvSel (auxEvSel),
    .strobe   (strobe)
  );

  qpc_datapath #(.W(W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .hystEn    (hystEn),
    .loadEn    (loadEn),
    .loadCnt   (loadCnt),
    .loadTop   (loadTop),
    .topBufWr  (topBufWr),
    .topBufData(topBufData),
    .flagSet   (flagSet),
    .flagClr   (flagClr),
    .intEnable (intEnable),
    .count     (count),
    .auxCount  (auxCount),
    .top       (top),
    .topBuf    (topBuf),
    .flags     (flags),
    .irq       (irq)
  );

endmodule

// File: rtl/qpc_checker.sv
`timescale 1ns/1ps
module qpc_checker #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rstN,
  input logic [2:0]   mode,
  input logic         loadEn,
  input logic [3:0]   flagSet,
  input logic [W-1:0] count,
  input logic [W-1:0] top,
  input logic [W-1:0] topBuf,
  input logic [3:0]   flags
, input logic         irq
);

  localparam logic [W-1:0] ONE = W'(1);

  // R6
  main_wrap_up_chk: assert property (@(posedge clk) disable iff (!rstN)
    (flags[0] && !$past(flags[0]) && !$past(flagSet[0])) |-> ($past(count) == $past(top)));

  // R10
  irq_source_chk: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> (flags != 4'b0000));

  // R2
  off_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (($past(mode) == 3'd0) && !$past(loadEn)) |-> $stable(count));

  // R9
  top_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!$stable(top) && !$past(loadEn)) |-> (top == $past(topBuf)));

  // R5
  step_size_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!$past(loadEn) && ($past(count) != '0) && ($past(count) < $past(top)))
      |-> (count == $past(count) || count == $past(count) + ONE || count == $past(count) - ONE));

endmodule

bind quad_pulse_counter qpc_checker #(.W(W)) u_chk (
  .clk    (clk),
  .rstN   (rstN),
  .mode   (mode),
  .loadEn (loadEn),
  .flagSet(flagSet),
  .count  (count),
  .top    (top),
  .topBuf (topBuf),
  .flags  (flags),
  .irq    (irq)
);

// File: tb/quad_pulse_counter_bench.sv
`timescale 1ns/1ps
module quad_pulse_counter_bench;

  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         s0 = 1'b0, s1 = 1'b0;
  logic [2:0]   mode = 3'd0;
  logic         negEdge = 1'b0, countDown = 1'b0, s1DirEn = 1'b0, hystEn = 1'b0;
  logic [1:0]   mainEvSel = 2'd1, auxEvSel = 2'd3;
  logic         loadEn = 1'b0;
  logic [W-1:0] loadCnt = '0, loadTop = '0;
  logic         topBufWr = 1'b0;
  logic [W-1:0] topBufData = '0;
  logic [3:0]   flagSet = '0, flagClr = '0, intEnable = '0;
  logic [W-1:0] count, auxCount, top, topBuf;
  logic [3:0]   flags;
  logic         irq;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  quad_pulse_counter #(.W(W)) u_quad_pulse_counter (.*);

  // mode, negEdge, countDown, s1DirEn, s0 steps, s1 steps, expected count (start 8)
  localparam int NV = 15;
  localparam logic [37:0] VEC [NV] = '{
    {3'd1, 1'b0, 1'b0, 1'b0, 8'hAA, 8'h00, 16'd12},
    {3'd1, 1'b1, 1'b0, 1'b0, 8'hAA, 8'h00, 16'd11},
    {3'd2, 1'b0, 1'b1, 1'b0, 8'hAA, 8'h00, 16'd4},
    {3'd1, 1'b0, 1'b0, 1'b1, 8'hAA, 8'h00, 16'd4},
    {3'd1, 1'b0, 1'b0, 1'b1, 8'hAA, 8'hFF, 16'd12},
    {3'd2, 1'b0, 1'b1, 1'b1, 8'hAA, 8'h00, 16'd12},
    {3'd6, 1'b0, 1'b0, 1'b0, 8'h66, 8'hCC, 16'd15},
    {3'd5, 1'b0, 1'b0, 1'b0, 8'h66, 8'hCC, 16'd12},
    {3'd4, 1'b0, 1'b0, 1'b0, 8'h66, 8'hCC, 16'd10},
    {3'd6, 1'b0, 1'b0, 1'b0, 8'hCC, 8'h66, 16'd1},
    {3'd6, 1'b1, 1'b0, 1'b0, 8'h66, 8'hCC, 16'd1},
    {3'd5, 1'b0, 1'b0, 1'b0, 8'hCC, 8'h66, 16'd5},
    {3'd3, 1'b0, 1'b0, 1'b0, 8'h66, 8'hCC, 16'd10},
    {3'd0, 1'b0, 1'b0, 1'b0, 8'hAA, 8'h00, 16'd8},
    {3'd7, 1'b0, 1'b0, 1'b0, 8'h66, 8'hCC, 16'd8}
  };

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic doLoad(input logic [W-1:0] c, input logic [W-1:0] t);
    loadCnt = c; loadTop = t; loadEn = 1'b1;
    tick(1);
    loadEn = 1'b0;
  endtask

  task automatic pulse();
    s0 = 1'b1; tick(3);
    s0 = 1'b0; tick(3);
  endtask

  task automatic finishRun();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    tick(3);
    rstN = 1'b1;
    tick(1);
    // R1 reset state
    chk("R1 count", count, 0);
    chk("R1 auxCount", auxCount, 0);
    chk("R1 top", top, 16'hFFFF);
    chk("R1 topBuf", topBuf, 16'hFFFF);
    chk("R1 flags", flags, 0);
    chk("R1 irq", irq, 0);

    // table: R2 R3 R4 R5
    mainEvSel = 2'd0;
    for (int v = 0; v < NV; v++) begin
      logic [37:0] e;
      e = VEC[v];
      mode = 3'd0;
      s0 = e[24]; s1 = e[16];
      tick(3);
      mode = e[37:35]; negEdge = e[34]; countDown = e[33]; s1DirEn = e[32];
      doLoad(16'd8, 16'd20);
      for (int i = 1; i < 8; i++) begin
        s0 = e[24+i]; s1 = e[16+i];
        tick(3);
      end
      checks++;
      if (count !== e[15:0]) begin
        errors++;
        $display("FAIL R2/R3/R4/R5 vector %0d: actual %0d expected %0d", v, count, e[15:0]);
      end
    end
    mode = 3'd0; s0 = 1'b0; s1 = 1'b0; tick(3);
    mode = 3'd1; negEdge = 1'b0; countDown = 1'b0; s1DirEn = 1'b0;

    // R11 latency
    doLoad(16'd1, 16'd20);
    s0 = 1'b1;
    tick(1);
    chk("R11 one edge", count, 1);
    tick(1);
    chk("R11 two edges", count, 2);
    s0 = 1'b0; tick(3);

    // R6 overflow wrap
    flagClr = 4'hF; tick(1); flagClr = 4'h0;
    doLoad(16'd4, 16'd5);
    pulse();
    chk("R6 at top", count, 5);
    pulse();
    chk("R6 wrap to 0", count, 0);
    chk("R6 overflow flag", flags, 4'b0001);
    // R10 masking
    chk("R10 irq masked", irq, 0);
    intEnable = 4'b0010; tick(1);
    chk("R10 irq other bit", irq, 0);
    intEnable = 4'b0001; tick(1);
    chk("R10 irq enabled", irq, 1);
    flagClr = 4'hF; tick(1); flagClr = 4'h0;
    chk("R10 cleared", flags, 0);
    chk("R10 irq low", irq, 0);

    // R6 underflow wrap
    countDown = 1'b1;
    pulse();
    chk("R6 wrap to top", count, 5);
    chk("R6 underflow flag", flags, 4'b0010);
    flagClr = 4'hF; tick(1); flagClr = 4'h0;

    // R7 hysteresis
    hystEn = 1'b1;
    countDown = 1'b0;
    doLoad(16'd10, 16'd10);
    pulse();
    chk("R7 overflow to half", count, 5);
    countDown = 1'b1;
    doLoad(16'd0, 16'd10);
    pulse();
    chk("R7 underflow to half", count, 5);
    hystEn = 1'b0; countDown = 1'b0;
    flagClr = 4'hF; tick(1); flagClr = 4'h0;

    // R9 staged top
    doLoad(16'd9, 16'd10);
    chk("R9 load top", top, 10);
    topBufData = 16'd3; topBufWr = 1'b1; tick(1); topBufWr = 1'b0;
    chk("R9 buffer written", topBuf, 3);
    chk("R9 top unchanged", top, 10);
    pulse();
    chk("R9 count at old top", count, 10);
    pulse();
    chk("R9 wrap count", count, 0);
    chk("R9 top copied", top, 3);
    for (int k = 0; k < 4; k++) pulse();
    chk("R9 new period", count, 0);
    flagClr = 4'hF; tick(1); flagClr = 4'h0;

    // R8 event select
    doLoad(16'd8, 16'd20);
    countDown = 1'b1; mainEvSel = 2'd1;
    pulse();
    chk("R8 up-only ignores down", count, 8);
    mainEvSel = 2'd2;
    pulse();
    chk("R8 down-only", count, 7);
    countDown = 1'b0; mainEvSel = 2'd3; auxEvSel = 2'd1;
    pulse();
    chk("R8 none holds main", count, 7);
    chk("R8 aux up", auxCount, 1);
    auxEvSel = 2'd2;
    pulse();
    chk("R8 aux down-only ignores up", auxCount, 1);
    countDown = 1'b1; auxEvSel = 2'd0;
    pulse();
    chk("R8 aux both", auxCount, 0);
    pulse();
    chk("R6 aux wrap", auxCount, 20);
    chk("R6 aux underflow flag", flags, 4'b1000);

    // R10 set/clear priority
    flagClr = 4'hF; tick(1); flagClr = 4'h0;
    flagSet = 4'b0100; tick(1); flagSet = 4'h0;
    chk("R10 software set", flags, 4'b0100);
    flagSet = 4'b0100; flagClr = 4'b0100; tick(1);
    flagSet = 4'h0; flagClr = 4'h0;
    chk("R10 set wins", flags, 4'b0100);
    intEnable = 4'b0100; tick(1);
    chk("R10 irq aux flag", irq, 1);

    finishRun();
  end

endmodule